// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block supervises software timing on a chip. A 7-bit down-counter steps once per prescaled period. The period comes from a fixed power-of-two divide of the bus clock (4096 by default) followed by a programmable divide of 1 to 128. Software must refresh the counter by writing the control register. The refresh has to fall inside a window: after the counter has dropped to or below a programmed window value, and before counter bit 6 clears. Once the watchdog is activated, a refresh that comes too early raises a reset request. So does a counter that runs out. Software can also force a reset on purpose by writing a counter value with bit 6 clear.

An early-warning flag is set when the counter steps down to 0x40. Software can then refresh the counter or log state before the reset arrives. The flag is set even when its interrupt is masked. The interrupt output is the flag gated by its enable. All access goes through a zero-wait-state APB slave with three registers. The bus carries no data stream, so every pin is plain control or status and there is no back-pressure.

Top module: `wwin_watchdog`

## Requirements
- R1: After reset, the control register (offset 0x0) reads 0x7F, the configuration register (offset 0x4) reads 0x7F and the status register (offset 0x8) reads 0. Both irq and rst_req are low.
- R2: The counter (control bits 6:0) decrements by one once every 2^(PRE_LOG2+TB) bus cycles, where TB is configuration bits 13:11. It wraps from 0x00 to 0x7F. A control write loads the counter but does not restart the prescaler.
- R3: The counter keeps running while the watchdog is not activated, and no control write ever raises rst_req in that state.
- R4: The activation bit (control bit 7) is set by writing 1 and is cleared only by the block reset. Writing 0 to it leaves it at 1.
- R5: When activated, a decrement from 0x40 to 0x3F raises rst_req in the cycle where the counter first reads 0x3F.
- R6: When the block was already activated, a control write made while the counter is above the window (configuration bits 6:0) raises rst_req in the next cycle.
- R7: A control write with bit 7 set and bit 6 clear raises rst_req in the next cycle, even if that write is the one that activates the watchdog.
- R8: A control write with bit 6 set, made while the counter is at or below the window, loads the counter and raises no reset.
- R9: The status flag (status bit 0) is set when the counter decrements to 0x40, whatever the value of the interrupt enable. Writing 0 to status bit 0 clears it and writing 1 has no effect. A set in the same cycle as a clear wins.
- R10: irq is high exactly when the flag and the interrupt enable (configuration bit 9) are both 1. The enable is set by writing 1 and is cleared only by reset.
- R11: Reserved bits read 0 and ignore writes. Any address other than 0x0, 0x4 and 0x8, such as 0xC, reads 0.
- R12: rst_req is a registered, active-high signal. A single cause produces a pulse that lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | AW | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| irq | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | Reset request pulse |

## Verification
The assertions check on every cycle that the counter holds unless the prescaler ticks or software writes it, and that each tick steps it down by exactly one. They also check that the activation and enable bits never fall, that the flag rises only on the step from 0x41 to 0x40, that a reset request appears only while the watchdog is activated, and that prescaler ticks are never adjacent. Only the bench scenarios can show the window rule as a whole. Those scenarios cover:
- an early refresh that resets and an in-window refresh that does not;
- the late timeout;
- the software reset;
- the set-versus-clear behaviour of the flag;
- counter wrap;
- prescaler phase being kept across a reload.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  localparam int CNT_W = 7;
  localparam int TB_W  = 3;
  localparam int DW    = 32;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CFG  = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  localparam int BIT_ACT   = 7;
  localparam int BIT_T6    = 6;
  localparam int BIT_EN    = 9;
  localparam int TB_LSB    = 11;
  localparam int BIT_FLAG  = 0;

  localparam logic [CNT_W-1:0] CNT_RST  = 7'h7F;
  localparam logic [CNT_W-1:0] CNT_WARN = 7'h40;
  localparam logic [CNT_W-1:0] CNT_PRE  = 7'h41;

  typedef struct packed {
    logic [TB_W-1:0]  tb;
    logic             en;
    logic [CNT_W-1:0] win;
  } cfg_t;
endpackage

// File: rtl/wwd_prescaler.sv
module wwd_prescaler #(
  parameter int PRE_LOG2 = 12,
  parameter int TB_W     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TB_W-1:0] tb,
  output logic            tick
);
  localparam int PW = PRE_LOG2 + (1 << TB_W) - 1;
  localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

  logic [PW-1:0] div_q;
  logic [PW-1:0] mask;

  assign mask = (ONE << (PRE_LOG2 + int'(tb))) - ONE;
  assign tick = (div_q & mask) == mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + ONE;
  end

  generate
    if (PRE_LOG2 > 0) begin : g_gap
      // R2: with a divide of two or more, ticks are never adjacent
      a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/wwd_regif.sv
module wwd_regif
  import wwd_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [DW-1:0]    pwdata,
  input  logic             act,
  input  logic [CNT_W-1:0] cnt,
  input  logic             flag,
  output logic             wr_ctrl,
  output logic             stat_clr,
  output logic [7:0]       ctrl_wdata,
  output cfg_t             cfg,
  output logic [DW-1:0]    prdata
);
  logic       hit;
  logic [1:0] sel;
  logic       wr;
  cfg_t       cfg_q;

  assign hit = (paddr[AW-1:4] == '0) && (paddr[1:0] == 2'b00);
  assign sel = paddr[3:2];
  assign wr  = psel && penable && pwrite && hit;

  assign wr_ctrl    = wr && (sel == SEL_CTRL);
  assign stat_clr   = wr && (sel == SEL_STAT) && !pwdata[BIT_FLAG];
  assign ctrl_wdata = pwdata[7:0];
  assign cfg        = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.tb  <= '0;
      cfg_q.en  <= 1'b0;
      cfg_q.win <= CNT_RST;
    end else if (wr && (sel == SEL_CFG)) begin
      cfg_q.tb  <= pwdata[TB_LSB +: TB_W];
      cfg_q.en  <= cfg_q.en | pwdata[BIT_EN];
      cfg_q.win <= pwdata[CNT_W-1:0];
    end
  end

  always_comb begin
    prdata = '0;
    if (hit) begin
      unique case (sel)
        SEL_CTRL: begin
          prdata[CNT_W-1:0] = cnt;
          prdata[BIT_ACT]   = act;
        end
        SEL_CFG: begin
          prdata[CNT_W-1:0]         = cfg_q.win;
          prdata[BIT_EN]            = cfg_q.en;
          prdata[TB_LSB +: TB_W]    = cfg_q.tb;
        end
        SEL_STAT: prdata[BIT_FLAG] = flag;
        default:  prdata = '0;
      endcase
    end
  end

  // R10: the enable bit never falls outside reset
  a_r10_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.en |=> cfg_q.en);
endmodule

// File: rtl/wwd_core.sv
module wwd_core
  import wwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_ctrl,
  input  logic [7:0]       ctrl_wdata,
  input  logic             stat_clr,
  input  logic [CNT_W-1:0] win,
  output logic [CNT_W-1:0] cnt,
  output logic             act,
  output logic             flag,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt_q;
  logic act_q, flag_q, rst_q;
  logic act_next, early, swr, late, warn_set, step;

  assign step     = tick && !wr_ctrl;
  assign act_next = act_q | (wr_ctrl & ctrl_wdata[BIT_ACT]);
  assign early    = wr_ctrl && act_q && (cnt_q > win);
  assign swr      = wr_ctrl && act_next && !ctrl_wdata[BIT_T6];
  assign late     = step && act_q && (cnt_q == CNT_WARN);
  assign warn_set = step && (cnt_q == CNT_PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_RST;
      act_q  <= 1'b0;
      flag_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      act_q <= act_next;
      rst_q <= early | swr | late;
      if (wr_ctrl)   cnt_q <= ctrl_wdata[CNT_W-1:0];
      else if (tick) cnt_q <= cnt_q - 1'b1;
      if (warn_set)      flag_q <= 1'b1;
      else if (stat_clr) flag_q <= 1'b0;
    end
  end

  assign cnt     = cnt_q;
  assign act     = act_q;
  assign flag    = flag_q;
  assign rst_req = rst_q;

  // R4: activation never clears outside reset
  a_r4_act_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |=> act_q);
  // R2: counter holds without a tick or a write
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_ctrl) |=> $stable(cnt_q));
  // R2: each tick steps the counter down by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_ctrl) |=> (cnt_q == $past(cnt_q) - 7'd1));
  // R9: flag rises only on the step to 0x40
  a_r9_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (cnt_q == CNT_WARN && $past(cnt_q) == CNT_PRE));
  // R12: a reset request only exists while activated
  a_r12_needs_act: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> act_q);
endmodule

// File: rtl/wwin_watchdog.sv
module wwin_watchdog
  import wwd_pkg::*;
#(
  parameter int AW       = 12,
  parameter int PRE_LOG2 = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          irq,
  output logic          rst_req
);
  logic             tick, wr_ctrl, stat_clr, act, flag;
  logic [7:0]       ctrl_wdata;
  logic [CNT_W-1:0] cnt;
  cfg_t             cfg;

  wwd_prescaler #(.PRE_LOG2(PRE_LOG2), .TB_W(TB_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tb(cfg.tb), .tick(tick));

  wwd_regif #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .act(act),
    .cnt(cnt), .flag(flag), .wr_ctrl(wr_ctrl), .stat_clr(stat_clr),
    .ctrl_wdata(ctrl_wdata), .cfg(cfg), .prdata(prdata));

  wwd_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_ctrl(wr_ctrl),
    .ctrl_wdata(ctrl_wdata), .stat_clr(stat_clr), .win(cfg.win),
    .cnt(cnt), .act(act), .flag(flag), .rst_req(rst_req));

  assign irq = flag & cfg.en;
endmodule

// File: tb/sim_wwin_watchdog.sv
`timescale 1ns/100ps
module sim_wwin_watchdog;
  localparam int AW = 12;
  localparam int PL = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic irq, rst_req;

  int vectors = 0, miscompares = 0, cyc = 0, rst_seen = 0, rst_hi = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference state
  int m_pcnt, m_cnt, m_win, m_tb;
  bit m_act, m_en, m_flag, m_rst;

  wwin_watchdog #(.AW(AW), .PRE_LOG2(PL)) u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .irq(irq), .rst_req(rst_req));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    int period, off;
    bit wr, tk, setf;
    if (!rst_n) begin
      m_pcnt = 0; m_cnt = 'h7F; m_win = 'h7F; m_tb = 0;
      m_act = 0; m_en = 0; m_flag = 0; m_rst = 0;
    end else begin
      period = (1 << PL) << m_tb;
      tk = (m_pcnt % period) == period - 1;
      m_pcnt = m_pcnt + 1;
      wr = psel && penable && pwrite && (paddr[AW-1:4] == 0) && (paddr[1:0] == 0);
      off = int'(paddr[3:2]);
      m_rst = 0; setf = 0;
      if (wr && off == 0) begin
        if (m_act && m_cnt > m_win) m_rst = 1;
        if ((m_act || pwdata[7]) && !pwdata[6]) m_rst = 1;
        m_act = m_act || pwdata[7];
        m_cnt = int'(pwdata[6:0]);
      end else if (tk) begin
        if (m_act && m_cnt == 'h40) m_rst = 1;
        if (m_cnt == 'h41) setf = 1;
        m_cnt = (m_cnt + 127) % 128;
      end
      if (setf) m_flag = 1;
      else if (wr && off == 2 && !pwdata[0]) m_flag = 0;
      if (wr && off == 1) begin
        m_tb = int'(pwdata[13:11]);
        m_en = m_en || pwdata[9];
        m_win = int'(pwdata[6:0]);
      end
    end
  end

  function automatic logic [31:0] exp_rd();
    logic [31:0] v = '0;
    if (paddr[AW-1:4] == 0 && paddr[1:0] == 0) begin
      case (paddr[3:2])
        2'd0: v = {24'd0, m_act, 7'(m_cnt)};
        2'd1: v = {18'd0, 3'(m_tb), 1'b0, m_en, 2'b0, 7'(m_win)};
        2'd2: v = {31'd0, m_flag};
        default: v = '0;
      endcase
    end
    return v;
  endfunction

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", t, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, away from both edges
  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst_req) begin rst_seen++; rst_hi++; end
    if (!done) begin
      chk({tag, " prdata"}, prdata, exp_rd());
      chk({tag, " irq"}, {31'd0, irq}, {31'd0, m_flag && m_en});
      chk({tag, " rst_req"}, {31'd0, rst_req}, {31'd0, m_rst});
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL R12 watchdog actual=%0d cycles expected=under 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic apb_wr(input logic [AW-1:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk) penable = 1;
    @(negedge clk) begin psel = 0; penable = 0; pwrite = 0; end
  endtask

  task automatic apb_rd(input logic [AW-1:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk) penable = 1;
    @(negedge clk) begin d = prdata; psel = 0; penable = 0; end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rst_seen = 0; rst_hi = 0;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    @(negedge clk);
    do_reset();

    tag = "R1";
    apb_rd('h0, rd); chk("R1 ctrl", rd, 32'h7F);
    apb_rd('h4, rd); chk("R1 cfg", rd, 32'h7F);
    apb_rd('h8, rd); chk("R1 stat", rd, 32'h0);
    chk("R1 irq/rst", {30'd0, irq, rst_req}, 32'd0);

    tag = "R3";
    apb_wr('h0, 32'h00);
    repeat (40) @(negedge clk);
    chk("R3 no reset while inactive", rst_seen, 0);

    tag = "R11";
    apb_wr('h4, 32'h8000_0C50);
    apb_rd('h4, rd); chk("R11 cfg readback", rd, 32'h0000_0850);
    apb_rd('hC, rd); chk("R11 unmapped", rd, 32'h0);

    tag = "R4";
    apb_wr('h0, 32'hC8);
    apb_wr('h0, 32'h48);
    apb_rd('h0, rd); chk("R4 act kept", {31'd0, rd[7]}, 32'd1);

    tag = "R9";
    for (int i = 0; i < 200; i++) begin
      apb_rd('h8, rd);
      if (rd[0]) break;
    end
    chk("R9 flag set with irq masked", {31'd0, rd[0]}, 32'd1);
    tag = "R8";
    apb_wr('h0, 32'hFF);
    chk("R8 in-window refresh", rst_seen, 0);
    tag = "R10";
    apb_wr('h4, 32'h0000_0A50);
    chk("R10 irq on", {31'd0, irq}, 32'd1);
    tag = "R9";
    apb_wr('h8, 32'h1);
    apb_rd('h8, rd); chk("R9 write 1 keeps flag", rd, 32'h1);
    apb_wr('h8, 32'h0);
    apb_rd('h8, rd); chk("R9 write 0 clears", rd, 32'h0);
    chk("R10 irq off", {31'd0, irq}, 32'd0);

    tag = "R6";
    apb_wr('h0, 32'hFF);
    @(negedge clk);
    chk("R6 early refresh resets", rst_seen, 1);

    do_reset();
    tag = "R5";
    apb_wr('h0, 32'hC2);
    repeat (40) @(negedge clk);
    chk("R5 late timeout resets", rst_seen, 1);
    chk("R12 one-cycle pulse", rst_hi, 1);

    do_reset();
    tag = "R7";
    apb_wr('h0, 32'h80);
    @(negedge clk);
    chk("R7 software reset", rst_seen, 1);

    do_reset();
    tag = "R2";
    apb_wr('h4, 32'h0000_107F);
    apb_wr('h0, 32'h01);
    repeat (96) @(negedge clk);
    apb_rd('h0, rd);
    chk("R2 wrapped count", {31'd0, (rd[6:0] == 7'h7D || rd[6:0] == 7'h7E)}, 32'd1);
    chk("R3 inactive no reset", rst_seen, 0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule